// File: doc/BRIEF.md
# Masked-Compare Sync Pattern Generator

This block produces a set of programmable timing pulses for a raster display pipeline. It contains its own raster position counter: a pixel column X runs from 0 to a programmable horizontal total minus one, then wraps and advances the line Y. Y in turn wraps at a programmable vertical total minus one. Both coordinates are 15 bits wide.

Each pulse generator compares the current position with two reference words, one that switches the pulse on and one that switches it off. Each reference word has its own mask, and a mask bit of 1 removes the matching position bit from the comparison. Masking all of Y gives an event on every line. Masking all of X gives an event at the start of a chosen line. A mask of zero gives a single point once per frame. Horizontal sync, vertical sync, the horizontal and vertical halves of the active-region enable, and a once-per-frame strobe can all be built from the same generator.

Software configures the totals and the generator words through a one-cycle register write port. The block has no read path.

Top module: `sync_pattern_gen`

## Requirements
- R1: While rst_n is low at a clock edge, every pulse output is 0 after that edge, and so are pix_x and pix_y. After reset the totals take their parameter defaults, and every generator word and mask is 0.
- R2: After each clock edge pix_x becomes pix_x+1, unless pix_x+1 is equal to or above the horizontal total. In that case pix_x becomes 0 and pix_y advances. pix_y becomes 0 instead of advancing when pix_y+1 is equal to or above the vertical total.
- R3: The position word carries X in bits 30:16 and Y in bits 14:0. Bits 31 and 15 of reference words are never part of the comparison.
- R4: A reference word matches when every position bit whose mask bit is 0 equals the corresponding reference bit. Masked bits are ignored.
- R5: A pulse output goes to 1 on the clock edge that follows a cycle in which its on-reference matched. It goes to 0 on the edge that follows a cycle in which its off-reference matched. Otherwise it holds its value.
- R6: If the on-reference and the off-reference match in the same cycle, the output goes to 0.
- R7: Write map, using byte addresses with cfg_we high for one cycle. 0x00 holds the horizontal total and 0x04 holds the vertical total, each in bits 15:0. Generator n sits at 0x60+16·n: +0 is the on-reference, +4 the on-mask, +8 the off-reference and +C the off-mask. Writes to any other address, including unaligned ones, change nothing.
- R8: With a mask of 0x0000FFFF, a generator switches at the programmed X on every line.
- R9: With a mask of 0x7FFF0000, a generator switches for the whole of the programmed line, so its level follows that line each frame. With a mask of 0, it switches at one point per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Byte address of the write |
| cfg_wdata | input | 32 | Write data |
| pix_x | output | 15 | Current pixel column |
| pix_y | output | 15 | Current line |
| pulse_out | output | NUM_GEN (6) | Generator outputs, bit n from generator n |

## Verification
The bench programs a 10-by-6 raster in which every generator's edges fall inside one frame. It samples outputs at chosen positions right before and right after each edge, so a design whose edges are late or early by one clock shows a wrong level at exactly one of those positions. One generator carries junk in bits 31 and 15 of its on-reference. A design that compares the unused bits would never raise that pulse. Another generator is given identical on and off points. A design that lets the on condition win would latch high forever. Writes to an unused address, an unaligned address and the address just past the last generator are followed by wrap checks and the vector walk, which exposes a decoder that aliases those writes onto real registers.

// File: rtl/sync_pg_pkg.sv
// Shared constants and types for the sync pattern generator.
// Assumes a 15-bit coordinate packed into a 32-bit position word.
package sync_pg_pkg;
    localparam int COORD_W   = 15;
    localparam int WORD_W    = 32;
    localparam int X_LSB     = 16;
    localparam int ADDR_W    = 9;
    localparam int GEN_BASE  = 'h60;
    localparam int GEN_STEP  = 16;
    localparam int HTOT_ADDR = 'h00;
    localparam int VTOT_ADDR = 'h04;
    localparam logic [WORD_W-1:0] VALID_BITS = 32'h7FFF_7FFF;

    // Four configuration words of one generator
    typedef struct packed {
        logic [WORD_W-1:0] on_ref;
        logic [WORD_W-1:0] on_mask;
        logic [WORD_W-1:0] off_ref;
        logic [WORD_W-1:0] off_mask;
    } gen_cfg_t;
endpackage

// File: rtl/raster_counter.sv
// Raster position counter: X runs 0..htotal-1, then wraps and advances Y,
// Y wraps after vtotal-1. A total of 0 or 1 keeps that coordinate at 0.
// Assumes totals change only between frames if glitch-free timing matters.
module raster_counter #(
    parameter int COORD_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W:0]   htotal,
    input  logic [COORD_W:0]   vtotal,
    output logic [COORD_W-1:0] x,
    output logic [COORD_W-1:0] y
);
    logic [COORD_W:0] x_inc;
    logic [COORD_W:0] y_inc;

    // Next-value candidates, one bit wider to avoid overflow in the compare
    always_comb begin
        x_inc = {1'b0, x} + 1'b1;
        y_inc = {1'b0, y} + 1'b1;
    end

    // Advance the column, wrapping into the next line and frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (x_inc >= htotal) begin
            x <= '0;
            y <= (y_inc >= vtotal) ? '0 : y_inc[COORD_W-1:0];
        end else begin
            x <= x_inc[COORD_W-1:0];
        end
    end
endmodule

// File: rtl/masked_match.sv
// Combinational masked comparison of a position word with a reference.
// Mask bit 1 drops that bit; bits outside VALID never take part.
module masked_match #(
    parameter int              WORD_W = 32,
    parameter logic [WORD_W-1:0] VALID = '1
) (
    input  logic [WORD_W-1:0] pos_word,
    input  logic [WORD_W-1:0] ref_word,
    input  logic [WORD_W-1:0] mask_word,
    output logic              hit
);
    // Equal when no compared bit differs
    always_comb hit = (((pos_word ^ ref_word) & ~mask_word & VALID) == '0);
endmodule

// File: rtl/sync_regfile.sv
// Write-only configuration store: two raster totals and NUM_GEN generator
// slots of four words each. Assumes word-aligned byte addresses; any other
// address is dropped.
module sync_regfile
    import sync_pg_pkg::*;
#(
    parameter int NUM_GEN    = 6,
    parameter int DEF_HTOTAL = 800,
    parameter int DEF_VTOTAL = 525
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [WORD_W-1:0]         wdata,
    output logic [COORD_W:0]          htotal,
    output logic [COORD_W:0]          vtotal,
    output gen_cfg_t [NUM_GEN-1:0]    gen_cfg
);
    localparam int IDX_W   = ADDR_W - 4;
    localparam int GEN_END = GEN_BASE + GEN_STEP * NUM_GEN;

    logic [ADDR_W-1:0] rel;
    logic              in_gen;

    // Offset into the generator window and its range test
    always_comb begin
        rel    = addr - ADDR_W'(GEN_BASE);
        in_gen = (32'(addr) >= GEN_BASE) && (32'(addr) < GEN_END) && (addr[1:0] == 2'b00);
    end

    // Raster totals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htotal <= (COORD_W+1)'(DEF_HTOTAL);
            vtotal <= (COORD_W+1)'(DEF_VTOTAL);
        end else if (we) begin
            if (32'(addr) == HTOT_ADDR) htotal <= wdata[COORD_W:0];
            if (32'(addr) == VTOT_ADDR) vtotal <= wdata[COORD_W:0];
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_slot
        logic sel;
        always_comb sel = we && in_gen && (rel[ADDR_W-1:4] == IDX_W'(g));

        // Word select within one generator slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gen_cfg[g] <= '0;
            end else if (sel) begin
                case (rel[3:2])
                    2'd0:    gen_cfg[g].on_ref   <= wdata;
                    2'd1:    gen_cfg[g].on_mask  <= wdata;
                    2'd2:    gen_cfg[g].off_ref  <= wdata;
                    default: gen_cfg[g].off_mask <= wdata;
                endcase
            end
        end
    end
endmodule

// File: rtl/sync_pattern_gen.sv
// Top level: raster counter, configuration store and NUM_GEN pulse
// generators. Each output is registered: it reacts one clock after the
// position that matched, and an off match overrides an on match.
module sync_pattern_gen
    import sync_pg_pkg::*;
#(
    parameter int NUM_GEN    = 6,
    parameter int DEF_HTOTAL = 800,
    parameter int DEF_VTOTAL = 525
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [8:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [14:0]        pix_x,
    output logic [14:0]        pix_y,
    output logic [NUM_GEN-1:0] pulse_out
);
    logic [COORD_W:0]       htotal;
    logic [COORD_W:0]       vtotal;
    gen_cfg_t [NUM_GEN-1:0] gen_cfg;
    logic [WORD_W-1:0]      pos_word;
    logic [NUM_GEN-1:0]     on_hit;
    logic [NUM_GEN-1:0]     off_hit;

    sync_regfile #(
        .NUM_GEN(NUM_GEN), .DEF_HTOTAL(DEF_HTOTAL), .DEF_VTOTAL(DEF_VTOTAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .htotal(htotal), .vtotal(vtotal), .gen_cfg(gen_cfg)
    );

    raster_counter #(.COORD_W(COORD_W)) u_raster (
        .clk(clk), .rst_n(rst_n), .htotal(htotal), .vtotal(vtotal),
        .x(pix_x), .y(pix_y)
    );

    // Pack the current position: X in the upper half, Y in the lower
    always_comb begin
        pos_word = '0;
        pos_word[X_LSB +: COORD_W] = pix_x;
        pos_word[COORD_W-1:0]      = pix_y;
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        masked_match #(.WORD_W(WORD_W), .VALID(VALID_BITS)) u_on (
            .pos_word(pos_word), .ref_word(gen_cfg[g].on_ref),
            .mask_word(gen_cfg[g].on_mask), .hit(on_hit[g])
        );
        masked_match #(.WORD_W(WORD_W), .VALID(VALID_BITS)) u_off (
            .pos_word(pos_word), .ref_word(gen_cfg[g].off_ref),
            .mask_word(gen_cfg[g].off_mask), .hit(off_hit[g])
        );

        // Pulse state: off has priority over on
        always_ff @(posedge clk) begin
            if (!rst_n)          pulse_out[g] <= 1'b0;
            else if (off_hit[g]) pulse_out[g] <= 1'b0;
            else if (on_hit[g])  pulse_out[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_pattern_gen_chk.sv
// Checker for sync_pattern_gen: raster stepping and pulse edge rules.
// Bound to every instance of the top module.
module sync_pattern_gen_chk #(
    parameter int NUM_GEN = 6,
    parameter int COORD_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic [COORD_W:0]   htotal,
    input logic [COORD_W:0]   vtotal,
    input logic [NUM_GEN-1:0] on_hit,
    input logic [NUM_GEN-1:0] off_hit,
    input logic [NUM_GEN-1:0] pulse_out
);
    logic [COORD_W:0] x_nxt;
    logic [COORD_W:0] y_nxt;
    always_comb begin
        x_nxt = {1'b0, pix_x} + 1'b1;
        y_nxt = {1'b0, pix_y} + 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pulse_out == '0 && pix_x == '0 && pix_y == '0));

    assert_x_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_nxt < htotal) |=> (pix_x == $past(x_nxt[COORD_W-1:0])));

    assert_x_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_nxt >= htotal) |=> (pix_x == '0));

    assert_y_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_nxt >= htotal && y_nxt >= vtotal) |=> (pix_y == '0));

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        assert_off_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            off_hit[g] |=> !pulse_out[g]);

        assert_on_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (on_hit[g] && !off_hit[g]) |=> pulse_out[g]);

        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!on_hit[g] && !off_hit[g] && $past(rst_n)) |=> $stable(pulse_out[g]));
    end
endmodule

bind sync_pattern_gen sync_pattern_gen_chk #(
    .NUM_GEN(NUM_GEN), .COORD_W(15)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .htotal(htotal), .vtotal(vtotal), .on_hit(on_hit), .off_hit(off_hit),
    .pulse_out(pulse_out)
);

// File: tb/sync_pattern_gen_tb.sv
// Bench: programs a 10x6 raster, walks a vector table of (x, y, expected
// pulses), then directed checks for reset, wrap, dropped writes and priority.
module sync_pattern_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [8:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [14:0]   pix_x;
    logic [14:0]   pix_y;
    logic [NG-1:0] pulse_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sync_pattern_gen #(.NUM_GEN(NG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_x(pix_x), .pix_y(pix_y), .pulse_out(pulse_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {x[3:0], y[3:0], expected pulse_out[5:0]}, in raster order.
    // Generators: 0 hsync X3..X6 Y masked (R8), 1 point (3,2)->(3,4) (R9),
    // 2 enable X0..X8 (R8), 3 line Y0..Y4 X masked (R9), 4 strobe on line 5,
    // 5 on-reference with junk in bits 31 and 15 (R3).
    localparam logic [13:0] VEC_TAB [0:14] = '{
        {4'd0, 4'd0, 6'h00}, {4'd1, 4'd0, 6'h0C}, {4'd4, 4'd0, 6'h0D},
        {4'd7, 4'd0, 6'h0C}, {4'd9, 4'd0, 6'h08}, {4'd2, 4'd1, 6'h2C},
        {4'd8, 4'd1, 6'h0C}, {4'd3, 4'd2, 6'h0C}, {4'd4, 4'd2, 6'h0F},
        {4'd0, 4'd4, 6'h0A}, {4'd1, 4'd4, 6'h06}, {4'd4, 4'd4, 6'h05},
        {4'd1, 4'd5, 6'h14}, {4'd2, 4'd5, 6'h14}, {4'd3, 4'd5, 6'h04}
    };

    function automatic logic [31:0] pk(input int x, input int y);
        return {1'b0, 15'(x), 1'b0, 15'(y)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 9'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_gen(input int g, input logic [31:0] onr, input logic [31:0] onm,
                          input logic [31:0] offr, input logic [31:0] offm);
        wr('h60 + 16*g + 0, onr);
        wr('h60 + 16*g + 4, onm);
        wr('h60 + 16*g + 8, offr);
        wr('h60 + 16*g + 12, offm);
    endtask

    task automatic wait_pos(input int x, input int y);
        do @(negedge clk); while (!(int'(pix_x) == x && int'(pix_y) == y));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int highs;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pulse_out == '0, "R1 pulses", int'(pulse_out), 0);
        check(pix_x == '0 && pix_y == '0, "R1 position", int'({pix_y, pix_x}), 0);
        rst_n = 1'b1;

        // R7: totals and generator slots
        wr('h00, 32'd10);
        wr('h04, 32'd6);
        wr_gen(0, pk(3,0), 32'h0000_FFFF, pk(6,0), 32'h0000_FFFF);
        wr_gen(1, pk(3,2), 32'h0, pk(3,4), 32'h0);
        wr_gen(2, pk(0,0), 32'h0000_FFFF, pk(8,0), 32'h0000_FFFF);
        wr_gen(3, pk(0,0), 32'h7FFF_0000, pk(0,4), 32'h7FFF_0000);
        wr_gen(4, pk(0,5), 32'h0, pk(2,5), 32'h0);
        wr_gen(5, 32'h8001_8001, 32'h0, pk(7,1), 32'h0);

        // R7: writes that must be dropped (unused, unaligned, past last slot)
        wr('h08, 32'd3);
        wr('h62, 32'h0);
        wr('h61, 32'h0);
        wr('h60 + 16*NG, 32'd2);
        wr('h60 + 16*NG + 4, 32'h0);

        // Let two full frames settle
        repeat (130) @(negedge clk);

        // Vector walk: R3/R4/R5/R8/R9
        for (int i = 0; i < 15; i++) begin
            wait_pos(int'(VEC_TAB[i][13:10]), int'(VEC_TAB[i][9:6]));
            check(pulse_out == VEC_TAB[i][5:0], "R3/R4/R5/R8/R9 vector",
                  int'(pulse_out), int'(VEC_TAB[i][5:0]));
        end

        // R2: line wrap and frame wrap with totals 10 and 6
        wait_pos(9, 2);
        @(negedge clk);
        check(pix_x == 15'd0 && pix_y == 15'd3, "R2 line wrap",
              int'({pix_y, pix_x}), int'({15'd3, 15'd0}));
        wait_pos(9, 5);
        @(negedge clk);
        check(pix_x == 15'd0 && pix_y == 15'd0, "R2 frame wrap",
              int'({pix_y, pix_x}), 0);
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pix_x == 15'd0 && pix_y == 15'd0) highs++;
        end
        check(highs == 1, "R2 frame length 60", highs, 1);

        // R6: identical on and off points never raise the pulse
        wr_gen(5, pk(2,3), 32'h0, pk(2,3), 32'h0);
        repeat (60) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (pulse_out[5]) highs++;
        end
        check(highs == 0, "R6 off wins", highs, 0);

        // R1: reset in mid-frame clears outputs and position
        wait_pos(5, 0);
        check(pulse_out[0] && pulse_out[2], "R8 pulses high before reset",
              int'(pulse_out), 'h0D);
        rst_n = 1'b0;
        @(negedge clk);
        check(pulse_out == '0 && pix_x == '0 && pix_y == '0, "R1 mid-frame reset",
              int'(pulse_out), 0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule